// File: doc/BRIEF.md
# Indirect Register File Address Resolver

This block turns an instruction's register operand into the address that the banked register file actually uses. A small direct operand normally selects a location in the bank named by the bank-select bits. One direct address is reserved as a pseudo-register that has no storage. Naming that address redirects the access through an 8-bit pointer register. The pointer is extended to 9 bits with a separate indirect bank bit, which becomes the top bit of the effective address.

The pointer register sits inside this block. It is written through ordinary data writes to its own address in any bank, whether that address is named directly or reached through the pointer. The block reports the kind of target on each access. The register file is enabled only for ordinary locations. A read of the pointer is flagged so that the datapath can return its value. An access in which the pointer names the pseudo-register itself is safe: a read of it returns zero, and a write to it stores nothing.

Top module: `ind_addr_resolver`

## Requirements
- R1: After reset the pointer value `ptr_val` is 0x00.
- R2: When `dir_addr` is not the pseudo-register address (0x00), `eff_addr` equals `dir_bank` (2 bits) placed above the 7-bit `dir_addr`, and the pointer value has no effect on it.
- R3: When `dir_addr` is 0x00, `eff_addr` equals `ind_bank` (the MSB) placed above the 8-bit pointer.
- R4: In an indirect access whose pointer low 7 bits are 0x00, a read raises `rd_zero` and keeps `rf_rd_en` low.
- R5: In an indirect access whose pointer low 7 bits are 0x00, a write keeps `rf_wr_en` low and leaves the pointer unchanged.
- R6: The self-reference check ignores pointer bit 7, so pointers 0x00 and 0x80 both count as the pseudo-register.
- R7: A write whose target has low 7 bits equal to the pointer address (0x04), in any bank, loads `wr_data` into the pointer at the next clock edge. In that case `rf_wr_en` stays low.
- R8: A read whose target is the pointer address raises `rd_ptr` and keeps `rf_rd_en` low.
- R9: For any other target, `rf_rd_en` follows `rd_req` and `rf_wr_en` follows `wr_req`, and both `rd_zero` and `rd_ptr` stay low.
- R10: An indirect write whose pointer low 7 bits are 0x04 loads the pointer, in the same way as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_addr | input | 7 | Direct register operand from the instruction |
| dir_bank | input | 2 | Bank bits for direct accesses |
| ind_bank | input | 1 | Bank bit for indirect accesses |
| rd_req | input | 1 | Access reads its operand |
| wr_req | input | 1 | Access writes its operand |
| wr_data | input | 8 | Data written by the access |
| eff_addr | output | 9 | Resolved register file address |
| rf_rd_en | output | 1 | Register file read enable |
| rf_wr_en | output | 1 | Register file write enable |
| rd_zero | output | 1 | Read data must be forced to zero |
| rd_ptr | output | 1 | Read data must come from the pointer |
| ptr_val | output | 8 | Current pointer value |

## Verification
The hardest case to reach is the pseudo-register naming itself. Getting there needs a pointer whose low 7 bits are zero, so the stimulus first writes 0x00 and then 0x80 into the pointer through its direct address, and only then issues indirect reads and writes. The indirect write that reloads the pointer through itself also depends on earlier state. The bench first loads 0x84 directly and then writes through the pseudo-register. A pointer-driven clear loop over 0x40 to 0x4F runs the sequence of incrementing the pointer and stopping on bit 4, and a pseudo-random phase mixes every kind of target.

// File: rtl/ind_addr_pkg.sv
package ind_addr_pkg;
    typedef enum logic [1:0] {
        TGT_FILE = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_SELF = 2'd2
    } tgt_e;
endpackage

// File: rtl/ind_addr_decode.sv
module ind_addr_decode
    import ind_addr_pkg::*;
#(
    parameter int DIR_W    = 7,
    parameter int PTR_W    = 8,
    parameter int IND_ADDR = 0,
    parameter int PTR_ADDR = 4,
    localparam int EA_W    = PTR_W + 1,
    localparam int BANK_W  = EA_W - DIR_W
) (
    input  logic [DIR_W-1:0]  dir_addr,
    input  logic [BANK_W-1:0] dir_bank,
    input  logic              ind_bank,
    input  logic [PTR_W-1:0]  ptr,
    output logic [EA_W-1:0]   eff_addr,
    output tgt_e              tgt
);
    localparam logic [DIR_W-1:0] IND_A = DIR_W'(IND_ADDR);
    localparam logic [DIR_W-1:0] PTR_A = DIR_W'(PTR_ADDR);

    logic is_ind;
    logic [DIR_W-1:0] low_sel;

    always_comb begin
        is_ind = (dir_addr == IND_A);
        if (is_ind) begin
            eff_addr = {ind_bank, ptr};
        end else begin
            eff_addr = {dir_bank, dir_addr};
        end
        low_sel = eff_addr[DIR_W-1:0];
        if (is_ind && (low_sel == IND_A)) begin
            tgt = TGT_SELF;
        end else if (low_sel == PTR_A) begin
            tgt = TGT_PTR;
        end else begin
            tgt = TGT_FILE;
        end
    end
endmodule

// File: rtl/ind_ptr_reg.sv
module ind_ptr_reg #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] din,
    output logic [PTR_W-1:0] ptr
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ptr = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/ind_addr_resolver.sv
module ind_addr_resolver
    import ind_addr_pkg::*;
#(
    parameter int DIR_W    = 7,
    parameter int PTR_W    = 8,
    parameter int IND_ADDR = 0,
    parameter int PTR_ADDR = 4,
    localparam int EA_W    = PTR_W + 1,
    localparam int BANK_W  = EA_W - DIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIR_W-1:0]  dir_addr,
    input  logic [BANK_W-1:0] dir_bank,
    input  logic              ind_bank,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [PTR_W-1:0]  wr_data,
    output logic [EA_W-1:0]   eff_addr,
    output logic              rf_rd_en,
    output logic              rf_wr_en,
    output logic              rd_zero,
    output logic              rd_ptr,
    output logic [PTR_W-1:0]  ptr_val
);
    tgt_e tgt;
    logic ptr_load;

    ind_addr_decode #(
        .DIR_W(DIR_W), .PTR_W(PTR_W), .IND_ADDR(IND_ADDR), .PTR_ADDR(PTR_ADDR)
    ) u_dec (
        .dir_addr(dir_addr), .dir_bank(dir_bank), .ind_bank(ind_bank),
        .ptr(ptr_val), .eff_addr(eff_addr), .tgt(tgt)
    );

    always_comb begin
        rf_rd_en = rd_req && (tgt == TGT_FILE);
        rf_wr_en = wr_req && (tgt == TGT_FILE);
        rd_zero  = rd_req && (tgt == TGT_SELF);
        rd_ptr   = rd_req && (tgt == TGT_PTR);
        ptr_load = wr_req && (tgt == TGT_PTR);
    end

    ind_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .din(wr_data), .ptr(ptr_val)
    );
endmodule

// File: rtl/ind_addr_checker.sv
module ind_addr_checker #(
    parameter int DIR_W    = 7,
    parameter int PTR_W    = 8,
    parameter int IND_ADDR = 0,
    parameter int PTR_ADDR = 4,
    localparam int EA_W    = PTR_W + 1,
    localparam int BANK_W  = EA_W - DIR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIR_W-1:0]  dir_addr,
    input logic [BANK_W-1:0] dir_bank,
    input logic              ind_bank,
    input logic              rd_req,
    input logic              wr_req,
    input logic [PTR_W-1:0]  wr_data,
    input logic [EA_W-1:0]   eff_addr,
    input logic              rf_rd_en,
    input logic              rf_wr_en,
    input logic              rd_zero,
    input logic              rd_ptr,
    input logic [PTR_W-1:0]  ptr_val
);
    localparam logic [DIR_W-1:0] IND_A = DIR_W'(IND_ADDR);
    localparam logic [DIR_W-1:0] PTR_A = DIR_W'(PTR_ADDR);

    p_direct_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_addr != IND_A) |-> (eff_addr == {dir_bank, dir_addr}));

    p_zero_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |-> (rd_req && !rf_rd_en && !rd_ptr));

    p_self_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && dir_addr == IND_A && ptr_val[DIR_W-1:0] == IND_A)
            |=> $stable(ptr_val));

    p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && dir_addr == PTR_A) |=> (ptr_val == $past(wr_data)));

    p_wr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> wr_req);

    p_rd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_rd_en, rd_zero, rd_ptr}));
endmodule

bind ind_addr_resolver ind_addr_checker #(
    .DIR_W(DIR_W), .PTR_W(PTR_W), .IND_ADDR(IND_ADDR), .PTR_ADDR(PTR_ADDR)
) u_chk (.*);

// File: tb/tb_ind_addr_resolver.sv
`timescale 1ns/1ps
module tb_ind_addr_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] dir_addr = '0;
    logic [1:0] dir_bank = '0;
    logic       ind_bank = 1'b0;
    logic       rd_req = 1'b0;
    logic       wr_req = 1'b0;
    logic [7:0] wr_data = '0;
    logic [8:0] eff_addr;
    logic       rf_rd_en, rf_wr_en, rd_zero, rd_ptr;
    logic [7:0] ptr_val;

    int errors = 0;
    int checks = 0;
    int ref_ptr = 0;
    int cleared[$];

    always #2.5 clk = ~clk;

    ind_addr_resolver dut (
        .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .dir_bank(dir_bank),
        .ind_bank(ind_bank), .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
        .eff_addr(eff_addr), .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en),
        .rd_zero(rd_zero), .rd_ptr(rd_ptr), .ptr_val(ptr_val)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one access at the falling edge, check before the rising edge,
    // then advance the reference pointer.
    task automatic step(int rd, int wr, int da, int db, int ib, int data);
        int exp_ea, kind, low;
        rd_req = rd[0]; wr_req = wr[0]; dir_addr = 7'(da);
        dir_bank = 2'(db); ind_bank = ib[0]; wr_data = 8'(data);
        #1;
        if (da == 0) exp_ea = ib * 256 + ref_ptr;
        else         exp_ea = db * 128 + da;
        low = exp_ea % 128;
        if (da == 0 && low == 0) kind = 2;
        else if (low == 4)       kind = 1;
        else                     kind = 0;
        check(da == 0 ? "R3 eff_addr" : "R2 eff_addr", eff_addr, exp_ea);
        check(kind == 2 ? "R4/R6 rd_zero" : "R9 rd_zero", rd_zero, (rd != 0 && kind == 2));
        check(kind == 1 ? "R8 rd_ptr" : "R9 rd_ptr", rd_ptr, (rd != 0 && kind == 1));
        check("R9 rf_rd_en", rf_rd_en, (rd != 0 && kind == 0));
        check(kind == 2 ? "R5 rf_wr_en" : "R9 rf_wr_en", rf_wr_en, (wr != 0 && kind == 0));
        if (wr != 0 && kind == 0) cleared.push_back(exp_ea);
        @(posedge clk);
        if (wr != 0 && kind == 1) ref_ptr = data % 256;
        @(negedge clk);
        check(kind == 2 ? "R5 ptr hold" : (da == 0 ? "R10 ptr" : "R7 ptr"),
              ptr_val, ref_ptr);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int lfsr;
        repeat (3) @(negedge clk);
        check("R1 reset ptr", ptr_val, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ptr after release", ptr_val, 0);

        // R2: direct accesses in several banks
        step(1, 0, 7'h20, 0, 0, 0);
        step(1, 1, 7'h7f, 3, 1, 8'h11);
        step(0, 1, 7'h05, 2, 0, 8'h22);
        // R7: load pointer from bank 1 mirror
        step(0, 1, 7'h04, 1, 0, 8'h40);
        step(1, 0, 7'h04, 2, 0, 0);               // R8
        step(1, 0, 7'h31, 1, 0, 0);               // R2 pointer ignored
        // Clear loop 0x40..0x4F through the pseudo-register
        cleared.delete();
        for (int n = 0; n < 32 && (ref_ptr & 16) == 0; n++) begin
            step(0, 1, 7'h00, 0, 0, 0);
            step(1, 1, 7'h04, 0, 0, ref_ptr + 1);
        end
        check("R3 clear count", cleared.size(), 16);
        foreach (cleared[i]) check("R3 clear target", cleared[i], 8'h40 + i);
        // R4/R5/R6: self reference with pointer 0x00 and 0x80
        step(0, 1, 7'h04, 0, 0, 8'h00);
        step(1, 1, 7'h00, 0, 1, 8'h55);
        step(0, 1, 7'h04, 3, 0, 8'h80);
        step(1, 0, 7'h00, 0, 0, 0);
        step(0, 1, 7'h00, 0, 1, 8'h66);
        // R10: indirect write into the pointer itself
        step(0, 1, 7'h04, 0, 0, 8'h84);
        step(1, 1, 7'h00, 0, 1, 8'h9a);
        step(1, 0, 7'h00, 0, 0, 0);
        // Pseudo-random mix
        lfsr = 32'h1ace;
        for (int k = 0; k < 400; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hb400 : 0);
            step((lfsr >> 1) & 1, (lfsr >> 2) & 1,
                 ((lfsr >> 3) & 3) == 0 ? 0 : (((lfsr >> 3) & 3) == 1 ? 4 : (lfsr >> 5) & 127),
                 (lfsr >> 12) & 3, (lfsr >> 14) & 1, (lfsr >> 4) & 255);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule